// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Loader

This block accepts configuration for a frequency synthesizer over three slow, asynchronous wires: a serial data line, a serial clock and a load strobe. Every rising edge of the serial clock pushes one data bit into a 19-bit shift register. The most significant bit goes first. The last bit pushed in is a routing flag, and it ends up in position 0 of the word.

On the rising edge of the load strobe, the block decodes the word and copies it into one of two register banks. The routing flag picks the bank:

- **Reference bank:** a 14-bit reference divide ratio and four single-bit mode controls (prescaler modulus, phase-detector polarity, lock/monitor output select, charge-pump current select).
- **Divider bank:** a 7-bit swallow count and an 11-bit main count.

All three wires are synchronised into the system clock before use. The latched fields are held in registers and drive the outputs directly. A ratio or main count below the minimum legal value of 3 is rejected. After reset, the block raises a valid flag only once each bank has accepted a word.

Top module: `synth_cfg_loader`

## Requirements
- R1: While and after reset, every configuration output is zero and `cfg_valid` is low.
- R2: One bit is taken from `ser_data` on each rising edge of `ser_clk`, most significant bit first. After 19 edges, the first bit sent is in word position 18 and the last bit sent is in position 0.
- R3: A load with word bit 0 = 1 updates the reference bank. `ref_ratio` takes bits 14..1 (bit 1 is its LSB), `presc_small` takes bit 15, `pd_polarity` takes bit 16, `mon_select` takes bit 17 and `cp_high` takes bit 18.
- R4: A load with word bit 0 = 0 updates the divider bank. `swallow_cnt` takes bits 7..1 (bit 1 is its LSB) and `main_cnt` takes bits 18..8 (bit 8 is its LSB).
- R5: Outputs change only after a rising edge of `ser_load`. Shifting a word without a load strobe leaves every output unchanged.
- R6: A load into one bank leaves the other bank's outputs unchanged.
- R7: Serial clock edges while `ser_load` is high do not alter the shift register, so a later load reuses the previous word.
- R8: A reference word with a ratio below 3 is discarded, and so is a divider word with a main count below 3. The bank keeps its previous contents. A value of exactly 3 is accepted.
- R9: `cfg_valid` rises only once each bank has accepted at least one word since reset. After that it stays high until reset.
- R10: When more than 19 bits are shifted before a load, only the last 19 bits form the word.
- R11: The outputs are unchanged two system-clock edges after `ser_load` rises (set between edges) and are updated after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, acts on its rising edge |
| ref_ratio | output | 14 | Reference divide ratio |
| presc_small | output | 1 | Prescaler modulus select (1 selects the smaller pair) |
| pd_polarity | output | 1 | Phase detector polarity |
| mon_select | output | 1 | 1 selects the monitor output, 0 selects lock detect |
| cp_high | output | 1 | 1 selects the higher charge-pump current |
| swallow_cnt | output | 7 | Swallow counter preset |
| main_cnt | output | 11 | Main programmable counter preset |
| cfg_valid | output | 1 | Both banks have been loaded since reset |

## Verification
A shift register that is off by one position, or reversed, shows up as scrambled fields on the first load. The error appears three system clocks after the strobe rises, and it is most visible with asymmetric values such as a ratio of 1000 with mixed mode bits.

If the routing flag is decoded wrongly, the wrong bank changes and the other bank is not updated. Both banks are compared after every load, so this is caught at once.

A bad seen-bank flag shows `cfg_valid` rising too early or dropping, and the first-load sequences check it after every strobe.

Missing gating of the serial clock during a strobe, or a missing threshold check, only becomes visible at the next load. The bench performs that load directly after such a stimulus.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int unsigned REF_W     = 14;
  localparam int unsigned SWL_W     = 7;
  localparam int unsigned MAIN_W    = 11;
  localparam int unsigned WORD_W    = 1 + SWL_W + MAIN_W;
  localparam int unsigned MIN_RATIO = 3;

  typedef struct packed {
    logic             cp_high;
    logic             mon_select;
    logic             pd_polarity;
    logic             presc_small;
    logic [REF_W-1:0] ratio;
  } ref_bank_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main_cnt;
    logic [SWL_W-1:0]  swallow;
  } div_bank_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[W-2:0], bit_in};
  end

  assign word = sr_q;
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output ref_bank_t         ref_q,
  output div_bank_t         div_q,
  output logic              valid
);
  ref_bank_t ref_next;
  div_bank_t div_next;
  logic      to_ref, acc_ref, acc_div;
  logic      seen_ref_q, seen_div_q;

  always_comb begin
    to_ref               = word[0];
    ref_next.ratio       = word[REF_W:1];
    ref_next.presc_small = word[REF_W+1];
    ref_next.pd_polarity = word[REF_W+2];
    ref_next.mon_select  = word[REF_W+3];
    ref_next.cp_high     = word[REF_W+4];
    div_next.swallow     = word[SWL_W:1];
    div_next.main_cnt    = word[WORD_W-1:SWL_W+1];
    acc_ref = load &&  to_ref && (ref_next.ratio    >= REF_W'(MIN_RATIO));
    acc_div = load && !to_ref && (div_next.main_cnt >= MAIN_W'(MIN_RATIO));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q      <= '0;
      div_q      <= '0;
      seen_ref_q <= 1'b0;
      seen_div_q <= 1'b0;
      valid      <= 1'b0;
    end else begin
      if (acc_ref) begin
        ref_q      <= ref_next;
        seen_ref_q <= 1'b1;
      end
      if (acc_div) begin
        div_q      <= div_next;
        seen_div_q <= 1'b1;
      end
      valid <= (seen_ref_q || acc_ref) && (seen_div_q || acc_div);
    end
  end

  assert_no_update_without_load_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(ref_q) && $stable(div_q)));
  assert_div_kept_on_ref_load_R6: assert property (@(posedge clk) disable iff (rst)
    (load && word[0]) |=> $stable(div_q));
  assert_ref_kept_on_div_load_R6: assert property (@(posedge clk) disable iff (rst)
    (load && !word[0]) |=> $stable(ref_q));
  assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);
  assert_valid_needs_both_R9: assert property (@(posedge clk) disable iff (rst)
    valid |-> (ref_q.ratio != '0 && div_q.main_cnt != '0));
  assert_ratio_legal_R8: assert property (@(posedge clk) disable iff (rst)
    (ref_q.ratio == '0) || (ref_q.ratio >= REF_W'(MIN_RATIO)));
  assert_main_legal_R8: assert property (@(posedge clk) disable iff (rst)
    (div_q.main_cnt == '0) || (div_q.main_cnt >= MAIN_W'(MIN_RATIO)));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic [REF_W-1:0]  ref_ratio,
  output logic              presc_small,
  output logic              pd_polarity,
  output logic              mon_select,
  output logic              cp_high,
  output logic [SWL_W-1:0]  swallow_cnt,
  output logic [MAIN_W-1:0] main_cnt,
  output logic              cfg_valid
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0]   pins_s;
  logic              sclk_s, data_s, load_s;
  logic              sclk_d, load_d;
  logic              sclk_rise, load_rise;
  logic [WORD_W-1:0] word_w;
  ref_bank_t         ref_w;
  div_bank_t         div_w;

  cfg_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_load, ser_data, ser_clk}),
    .q   (pins_s)
  );

  assign {load_s, data_s, sclk_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      load_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      load_d <= load_s;
    end
  end

  assign sclk_rise = sclk_s && !sclk_d;
  assign load_rise = load_s && !load_d;

  cfg_shift #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sclk_rise && !load_s),
    .bit_in   (data_s),
    .word     (word_w)
  );

  cfg_bank u_bank (
    .clk   (clk),
    .rst   (rst),
    .load  (load_rise),
    .word  (word_w),
    .ref_q (ref_w),
    .div_q (div_w),
    .valid (cfg_valid)
  );

  assign ref_ratio   = ref_w.ratio;
  assign presc_small = ref_w.presc_small;
  assign pd_polarity = ref_w.pd_polarity;
  assign mon_select  = ref_w.mon_select;
  assign cp_high     = ref_w.cp_high;
  assign swallow_cnt = div_w.swallow;
  assign main_cnt    = div_w.main_cnt;

  assert_shift_frozen_in_load_R7: assert property (@(posedge clk) disable iff (rst)
    load_s |=> $stable(word_w));
  assert_shift_new_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !load_s) |=> (word_w[0] == $past(data_s)));
  assert_shift_moves_up_R2: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !load_s) |=> (word_w[WORD_W-1:1] == $past(word_w[WORD_W-2:0])));
  assert_reset_clean_R1: assert property (@(posedge clk)
    $past(rst) |-> (!cfg_valid && ref_ratio == '0 && main_cnt == '0));
endmodule

// File: tb/synth_cfg_loader_bench.sv
module synth_cfg_loader_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [13:0] ref_ratio;
  logic presc_small, pd_polarity, mon_select, cp_high, cfg_valid;
  logic [6:0]  swallow_cnt;
  logic [10:0] main_cnt;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  synth_cfg_loader u_synth_cfg_loader (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .ref_ratio(ref_ratio), .presc_small(presc_small), .pd_polarity(pd_polarity),
    .mon_select(mon_select), .cp_high(cp_high), .swallow_cnt(swallow_cnt),
    .main_cnt(main_cnt), .cfg_valid(cfg_valid)
  );

  function automatic logic [18:0] ref_word(logic [13:0] r, logic sw, logic pol, logic mon, logic cp);
    return {cp, mon, pol, sw, r, 1'b1};
  endfunction
  function automatic logic [18:0] div_word(logic [6:0] a, logic [10:0] n);
    return {n, a, 1'b0};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ref(input string req, input logic [13:0] r, input logic sw, pol, mon, cp);
    chk(req, "ref_ratio", 32'(ref_ratio), 32'(r));
    chk(req, "mode bits", 32'({presc_small, pd_polarity, mon_select, cp_high}), 32'({sw, pol, mon, cp}));
  endtask
  task automatic chk_div(input string req, input logic [6:0] a, input logic [10:0] n);
    chk(req, "swallow_cnt", 32'(swallow_cnt), 32'(a));
    chk(req, "main_cnt", 32'(main_cnt), 32'(n));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_reset();
    @(negedge clk); rst = 1'b1; idle(4); rst = 1'b0; idle(2);
  endtask
  task automatic shift_bit(input logic b);
    ser_data = b; idle(3); ser_clk = 1'b1; idle(3); ser_clk = 1'b0; idle(3);
  endtask
  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
  endtask
  task automatic strobe();
    @(negedge clk); ser_load = 1'b1; idle(4); ser_load = 1'b0; idle(4);
  endtask

  task automatic t_reset();
    do_reset();
    chk_ref("R1", 14'd0, 0, 0, 0, 0);
    chk_div("R1", 7'd0, 11'd0);
    chk("R1", "cfg_valid", 32'(cfg_valid), 0);
  endtask

  task automatic t_first_loads();
    send_bits(32'(ref_word(14'd1000, 1, 0, 1, 1)), 19); strobe();
    chk_ref("R3", 14'd1000, 1, 0, 1, 1);
    chk_div("R6", 7'd0, 11'd0);
    chk("R9", "valid after ref only", 32'(cfg_valid), 0);
    send_bits(32'(div_word(7'd5, 11'd300)), 19); strobe();
    chk_div("R4", 7'd5, 11'd300);
    chk_ref("R6", 14'd1000, 1, 0, 1, 1);
    chk("R9", "valid after both", 32'(cfg_valid), 1);
  endtask

  task automatic t_msb_order();
    send_bits(32'(ref_word(14'h2001, 0, 1, 0, 1)), 19); strobe();
    chk_ref("R2", 14'h2001, 0, 1, 0, 1);
    send_bits(32'(div_word(7'd127, 11'd2047)), 19); strobe();
    chk_div("R4", 7'd127, 11'd2047);
    send_bits(32'(ref_word(14'd16383, 1, 1, 1, 1)), 19); strobe();
    chk_ref("R3", 14'd16383, 1, 1, 1, 1);
  endtask

  task automatic t_no_strobe();
    send_bits(32'(div_word(7'd9, 11'd99)), 19); idle(8);
    chk_div("R5", 7'd127, 11'd2047);
    chk_ref("R5", 14'd16383, 1, 1, 1, 1);
  endtask

  task automatic t_latency();
    send_bits(32'(div_word(7'd33, 11'd444)), 19);
    @(negedge clk); ser_load = 1'b1;
    repeat (2) @(posedge clk); #2;
    chk("R11", "old main after two edges", 32'(main_cnt), 32'd2047);
    @(posedge clk); #2;
    chk("R11", "new main after three edges", 32'(main_cnt), 32'd444);
    idle(3); ser_load = 1'b0; idle(4);
  endtask

  task automatic t_shift_in_load();
    send_bits(32'(div_word(7'd17, 11'd600)), 19);
    @(negedge clk); ser_load = 1'b1; idle(4);
    send_bits(32'(div_word(7'd1, 11'd1500)), 19);
    ser_load = 1'b0; idle(4);
    strobe();
    chk_div("R7", 7'd17, 11'd600);
  endtask

  task automatic t_overlong();
    send_bits(32'h3F, 6);
    send_bits(32'(ref_word(14'd77, 0, 0, 0, 0)), 19); strobe();
    chk_ref("R10", 14'd77, 0, 0, 0, 0);
  endtask

  task automatic t_small_values();
    do_reset();
    send_bits(32'(div_word(7'd2, 11'd50)), 19); strobe();
    send_bits(32'(ref_word(14'd2, 1, 1, 1, 1)), 19); strobe();
    chk_ref("R8", 14'd0, 0, 0, 0, 0);
    chk("R9", "valid with rejected ref", 32'(cfg_valid), 0);
    send_bits(32'(ref_word(14'd3, 1, 0, 0, 1)), 19); strobe();
    chk_ref("R8", 14'd3, 1, 0, 0, 1);
    chk("R9", "valid after min ref", 32'(cfg_valid), 1);
    send_bits(32'(div_word(7'd4, 11'd2)), 19); strobe();
    chk_div("R8", 7'd2, 11'd50);
    send_bits(32'(div_word(7'd4, 11'd3)), 19); strobe();
    chk_div("R8", 7'd4, 11'd3);
    chk("R9", "valid sticky", 32'(cfg_valid), 1);
  endtask

  initial begin
    t_reset();
    t_first_loads();
    t_msb_order();
    t_no_strobe();
    t_latency();
    t_shift_in_load();
    t_overlong();
    t_small_values();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule